// File: doc/BRIEF.md
# Segment limit and rights checker

This block decides, for every memory access, whether the access may proceed under the cached descriptor of the segment it uses. A descriptor-load strobe captures the descriptor's limit, base pieces, granularity, default-size bit, presence bit, code/data flag and type bits. From these it prepares an effective limit, a 32-bit base, an expand-down flag, an address-space ceiling and a four-entry vector that says which access kinds the segment type forbids. The per-access check then uses only these stored values and the access inputs.

For each access the caller supplies a 33-bit offset, an access kind, a prefetch qualifier, whether the stack segment is used, and the current CPU mode. One clock later the block reports pass or fault, the fault class (general protection or stack), a cause code, whether an exception is to be raised, and whether the error code is a pseudo one rather than a plain zero. Walking descriptor tables and delivering the exception are left to the surrounding logic.

Top module: `seg_limit_checker`

## Requirements
- R1: The effective limit equals the 20-bit raw limit when granularity is 0; when granularity is 1 it is the raw limit shifted left by 12 with bits 11:0 set. With a normal (not expand-down) segment an offset passes the limit test exactly when offset <= effective limit, compared as unsigned 33-bit values.
- R2: After a load, `seg_base` equals {base_hi, base_mid, base_lo}, with base_hi in bits 31:24, base_mid in bits 23:16 and base_lo in bits 15:0.
- R3: A segment is expand-down when desc_cd=1, desc_type[2]=0 and desc_type[1]=1 (access byte masked with 0x1C equal to 0x14); for it the result of offset <= limit is inverted.
- R4: The ceiling is 0xFFFF when desc_db=0 and 0xFFFFFFFF when desc_db=1; an access to an expand-down segment whose offset exceeds the ceiling fails the limit test.
- R5: With desc_type holding access-byte bits 3:1 and acc_kind coded 0 write, 1 data read, 3 opcode fetch (2 unused): data types 0 and 2 (read-only) fault only on kind 0; data types 1 and 3 (read/write) never fault; code types 5 and 7 (readable) fault only on kind 0; code types 4 and 6 (execute-only) fault on every kind except 3. The rights check applies only when desc_cd=1; the prefetch qualifier never changes it.
- R6: Checks are ordered: not present gives cause 1; otherwise a rights violation gives cause 3; otherwise a limit failure gives cause 6; a passing access gives cause 0 and res_fault=0, any other cause gives res_fault=1.
- R7: res_stack_fault=1 exactly when the cause is 6 and acc_is_stack was 1; presence and rights faults, and limit faults on other segments, are general protection faults (res_stack_fault=0).
- R8: res_raise equals res_fault when acc_prefetch=0 and is 0 when acc_prefetch=1; res_fault is unaffected by acc_prefetch.
- R9: With acc_mode coded 0 real, 1 protected, 2 virtual-8086: res_pseudo=1 for a fault in real mode, and for a cause-6 fault in virtual-8086 mode; it is 0 in protected mode, for other virtual-8086 faults, and for passing accesses.
- R10: While rst is high, res_valid, res_fault, res_stack_fault, res_raise, res_pseudo, res_cause and seg_base are all 0.
- R11: Results appear one clock after the access (res_valid follows acc_valid with one cycle delay), and an access presented in the same cycle as a descriptor load is checked against the previously loaded descriptor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Descriptor load strobe |
| load_limit | input | 20 | Raw segment limit |
| load_base_lo | input | 16 | Base bits 15:0 |
| load_base_mid | input | 8 | Base bits 23:16 |
| load_base_hi | input | 8 | Base bits 31:24 |
| load_present | input | 1 | Descriptor present bit |
| load_cd | input | 1 | 1 for a code/data segment, 0 for a system segment |
| load_type | input | 3 | Access-byte type bits 3:1 |
| load_gran | input | 1 | Granularity bit |
| load_db | input | 1 | Default-size bit selecting the ceiling |
| acc_valid | input | 1 | Access present this cycle |
| acc_offset | input | 33 | Access offset |
| acc_kind | input | 2 | 0 write, 1 data read, 3 opcode fetch |
| acc_prefetch | input | 1 | Access is a prefetch |
| acc_is_stack | input | 1 | Access uses the stack segment |
| acc_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086 |
| res_valid | output | 1 | Result valid |
| res_fault | output | 1 | Access fails |
| res_stack_fault | output | 1 | Fault class is stack (else general protection) |
| res_cause | output | 3 | 0 pass, 1 not present, 3 rights, 6 limit |
| res_raise | output | 1 | Exception to be raised |
| res_pseudo | output | 1 | Pseudo error code applies |
| seg_base | output | 32 | Base of the loaded descriptor |

## Verification
On every cycle the assertions check the one-cycle relation between acc_valid and res_valid, the agreement of res_fault with a nonzero cause, that a stack fault only follows a stack access with cause 6, that no exception is raised for a prefetch, that protected mode never yields a pseudo code, and the cleared outputs after reset. The limit arithmetic with granularity, the expand-down inversion and ceiling, the rights table per type and kind, and the check ordering are shown only by the bench's sweep over every presence, class, type, granularity and size combination against offsets at and around the limit and both ceilings. Loading a descriptor in the same cycle as an access is a directed bench scenario.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_V86  = 2'd2
  } cpu_mode_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_NOTPRES = 3'd1,
    CAUSE_RIGHTS  = 3'd3,
    CAUSE_LIMIT   = 3'd6
  } fault_cause_e;

  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd3;

  // Bit k set: access kind k is forbidden for this type.
  // typ[2]: code segment, typ[0]: writable (data) or readable (code).
  function automatic logic [3:0] forbidden_kinds(input logic [2:0] typ);
    logic [3:0] v;
    if (!typ[2]) v = typ[0] ? 4'b0000 : 4'b0001;
    else         v = typ[0] ? 4'b0001 : 4'b0111;
    return v;
  endfunction

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int LIM_W   = 20,
  parameter int BLO_W   = 16,
  parameter int BMID_W  = 8,
  parameter int BHI_W   = 8,
  parameter int SHORT_W = 16,
  parameter int TYPE_W  = 3,
  localparam int ADDR_W = BLO_W + BMID_W + BHI_W,
  localparam int GRAN_SH = ADDR_W - LIM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [LIM_W-1:0]  load_limit,
  input  logic [BLO_W-1:0]  load_base_lo,
  input  logic [BMID_W-1:0] load_base_mid,
  input  logic [BHI_W-1:0]  load_base_hi,
  input  logic              load_present,
  input  logic              load_cd,
  input  logic [TYPE_W-1:0] load_type,
  input  logic              load_gran,
  input  logic              load_db,
  output logic [ADDR_W-1:0] eff_limit,
  output logic [ADDR_W-1:0] eff_base,
  output logic [ADDR_W-1:0] eff_ceil,
  output logic              is_topdown,
  output logic              is_present,
  output logic              is_cd,
  output logic [3:0]        forbid_vec
);
  import seg_chk_pkg::*;

  logic [ADDR_W-1:0] limit_calc;
  logic [ADDR_W-1:0] ceil_calc;

  always_comb begin
    if (load_gran) limit_calc = {load_limit, {GRAN_SH{1'b1}}};
    else           limit_calc = {{GRAN_SH{1'b0}}, load_limit};
    if (load_db)   ceil_calc  = {ADDR_W{1'b1}};
    else           ceil_calc  = {{(ADDR_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_limit  <= '0;
      eff_base   <= '0;
      eff_ceil   <= '0;
      is_topdown <= 1'b0;
      is_present <= 1'b0;
      is_cd      <= 1'b0;
      forbid_vec <= '0;
    end else if (load_en) begin
      eff_limit  <= limit_calc;
      eff_base   <= {load_base_hi, load_base_mid, load_base_lo};
      eff_ceil   <= ceil_calc;
      is_topdown <= load_cd & ~load_type[2] & load_type[1];
      is_present <= load_present;
      is_cd      <= load_cd;
      forbid_vec <= forbidden_kinds(load_type);
    end
  end

endmodule

// File: rtl/seg_limit_cmp.sv
module seg_limit_cmp #(
  parameter int ADDR_W = 32,
  localparam int OFS_W = ADDR_W + 1
) (
  input  logic [OFS_W-1:0]  offset,
  input  logic [ADDR_W-1:0] limit,
  input  logic [ADDR_W-1:0] ceil,
  input  logic              topdown,
  output logic              limit_ok
);
  logic below_limit;
  logic above_ceil;

  always_comb begin
    below_limit = offset <= {1'b0, limit};
    above_ceil  = offset >  {1'b0, ceil};
    limit_ok    = (below_limit ^ topdown) & ~(topdown & above_ceil);
  end

endmodule

// File: rtl/seg_fault_sel.sv
module seg_fault_sel (
  input  logic       present,
  input  logic       cd_seg,
  input  logic [3:0] forbid_vec,
  input  logic [1:0] kind,
  input  logic       limit_ok,
  input  logic       is_stack,
  input  logic       prefetch,
  input  logic [1:0] mode,
  output logic       fault,
  output logic       stack_fault,
  output logic [2:0] cause,
  output logic       raise,
  output logic       pseudo
);
  import seg_chk_pkg::*;

  fault_cause_e sel;

  always_comb begin
    if (!present)                          sel = CAUSE_NOTPRES;
    else if (cd_seg && forbid_vec[kind])   sel = CAUSE_RIGHTS;
    else if (!limit_ok)                    sel = CAUSE_LIMIT;
    else                                   sel = CAUSE_NONE;
    cause       = sel;
    fault       = (sel != CAUSE_NONE);
    stack_fault = (sel == CAUSE_LIMIT) && is_stack;
    raise       = fault && !prefetch;
    pseudo      = fault && (mode != MODE_PROT) &&
                  ((mode == MODE_REAL) || ((sel == CAUSE_LIMIT) && (mode == MODE_V86)));
  end

endmodule

// File: rtl/seg_limit_checker.sv
module seg_limit_checker #(
  parameter int LIM_W   = 20,
  parameter int BLO_W   = 16,
  parameter int BMID_W  = 8,
  parameter int BHI_W   = 8,
  parameter int SHORT_W = 16,
  parameter int TYPE_W  = 3,
  localparam int ADDR_W = BLO_W + BMID_W + BHI_W,
  localparam int OFS_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [LIM_W-1:0]  load_limit,
  input  logic [BLO_W-1:0]  load_base_lo,
  input  logic [BMID_W-1:0] load_base_mid,
  input  logic [BHI_W-1:0]  load_base_hi,
  input  logic              load_present,
  input  logic              load_cd,
  input  logic [TYPE_W-1:0] load_type,
  input  logic              load_gran,
  input  logic              load_db,
  input  logic              acc_valid,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [1:0]        acc_kind,
  input  logic              acc_prefetch,
  input  logic              acc_is_stack,
  input  logic [1:0]        acc_mode,
  output logic              res_valid,
  output logic              res_fault,
  output logic              res_stack_fault,
  output logic [2:0]        res_cause,
  output logic              res_raise,
  output logic              res_pseudo,
  output logic [ADDR_W-1:0] seg_base
);

  logic [ADDR_W-1:0] c_limit, c_ceil;
  logic              c_topdown, c_present, c_cd;
  logic [3:0]        c_forbid;
  logic              lim_ok;
  logic              n_fault, n_stack, n_raise, n_pseudo;
  logic [2:0]        n_cause;

  seg_desc_cache #(
    .LIM_W(LIM_W), .BLO_W(BLO_W), .BMID_W(BMID_W), .BHI_W(BHI_W),
    .SHORT_W(SHORT_W), .TYPE_W(TYPE_W)
  ) u_cache (
    .clk(clk), .rst(rst), .load_en(load_en),
    .load_limit(load_limit), .load_base_lo(load_base_lo),
    .load_base_mid(load_base_mid), .load_base_hi(load_base_hi),
    .load_present(load_present), .load_cd(load_cd), .load_type(load_type),
    .load_gran(load_gran), .load_db(load_db),
    .eff_limit(c_limit), .eff_base(seg_base), .eff_ceil(c_ceil),
    .is_topdown(c_topdown), .is_present(c_present), .is_cd(c_cd),
    .forbid_vec(c_forbid)
  );

  seg_limit_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .offset(acc_offset), .limit(c_limit), .ceil(c_ceil),
    .topdown(c_topdown), .limit_ok(lim_ok)
  );

  seg_fault_sel u_sel (
    .present(c_present), .cd_seg(c_cd), .forbid_vec(c_forbid),
    .kind(acc_kind), .limit_ok(lim_ok), .is_stack(acc_is_stack),
    .prefetch(acc_prefetch), .mode(acc_mode),
    .fault(n_fault), .stack_fault(n_stack), .cause(n_cause),
    .raise(n_raise), .pseudo(n_pseudo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid       <= 1'b0;
      res_fault       <= 1'b0;
      res_stack_fault <= 1'b0;
      res_cause       <= '0;
      res_raise       <= 1'b0;
      res_pseudo      <= 1'b0;
    end else begin
      res_valid       <= acc_valid;
      res_fault       <= acc_valid & n_fault;
      res_stack_fault <= acc_valid & n_stack;
      res_cause       <= acc_valid ? n_cause : 3'd0;
      res_raise       <= acc_valid & n_raise;
      res_pseudo      <= acc_valid & n_pseudo;
    end
  end

endmodule

// File: rtl/seg_limit_checker_sva.sv
module seg_limit_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_prefetch,
  input logic       acc_is_stack,
  input logic [1:0] acc_mode,
  input logic       res_valid,
  input logic       res_fault,
  input logic       res_stack_fault,
  input logic [2:0] res_cause,
  input logic       res_raise,
  input logic       res_pseudo
);

  // R11
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!res_valid && !res_fault && !res_raise));

  // R6
  fault_cause_agree_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_fault == (res_cause != 3'd0)));

  // R7
  stack_class_chk: assert property (@(posedge clk) disable iff (rst)
    res_stack_fault |-> (res_cause == 3'd6 && $past(acc_is_stack)));

  // R8
  no_raise_prefetch_chk: assert property (@(posedge clk) disable iff (rst)
    res_raise |-> (res_fault && !$past(acc_prefetch)));

  // R9
  no_pseudo_prot_chk: assert property (@(posedge clk) disable iff (rst)
    res_pseudo |-> (res_fault && $past(acc_mode) != 2'd1));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_fault && res_cause == 3'd0));

endmodule

bind seg_limit_checker seg_limit_checker_sva u_sva (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_prefetch(acc_prefetch),
  .acc_is_stack(acc_is_stack), .acc_mode(acc_mode), .res_valid(res_valid),
  .res_fault(res_fault), .res_stack_fault(res_stack_fault),
  .res_cause(res_cause), .res_raise(res_raise), .res_pseudo(res_pseudo)
);

// File: tb/seg_limit_checker_bench.sv
module seg_limit_checker_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        load_en;
  logic [19:0] load_limit;
  logic [15:0] load_base_lo;
  logic [7:0]  load_base_mid, load_base_hi;
  logic        load_present, load_cd, load_gran, load_db;
  logic [2:0]  load_type;
  logic        acc_valid;
  logic [32:0] acc_offset;
  logic [1:0]  acc_kind;
  logic        acc_prefetch, acc_is_stack;
  logic [1:0]  acc_mode;
  logic        res_valid, res_fault, res_stack_fault, res_raise, res_pseudo;
  logic [2:0]  res_cause;
  logic [31:0] seg_base;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model of the loaded descriptor
  logic [7:0]  m_ar;
  logic [19:0] m_raw;
  logic        m_g, m_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_limit_checker u_seg_limit_checker (
    .clk(clk), .rst(rst), .load_en(load_en), .load_limit(load_limit),
    .load_base_lo(load_base_lo), .load_base_mid(load_base_mid),
    .load_base_hi(load_base_hi), .load_present(load_present),
    .load_cd(load_cd), .load_type(load_type), .load_gran(load_gran),
    .load_db(load_db), .acc_valid(acc_valid), .acc_offset(acc_offset),
    .acc_kind(acc_kind), .acc_prefetch(acc_prefetch),
    .acc_is_stack(acc_is_stack), .acc_mode(acc_mode),
    .res_valid(res_valid), .res_fault(res_fault),
    .res_stack_fault(res_stack_fault), .res_cause(res_cause),
    .res_raise(res_raise), .res_pseudo(res_pseudo), .seg_base(seg_base)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive a descriptor from an access byte; takes effect at the next edge
  task automatic load_desc(input logic [7:0] ar, input logic [19:0] raw,
                           input logic g, input logic d, input logic [31:0] base);
    load_en = 1'b1;
    load_limit = raw;
    load_base_lo = base[15:0];
    load_base_mid = base[23:16];
    load_base_hi = base[31:24];
    load_present = ar[7];
    load_cd = ar[4];
    load_type = ar[3:1];
    load_gran = g;
    load_db = d;
    m_ar = ar; m_raw = raw; m_g = g; m_d = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  function automatic logic [2:0] exp_cause(input logic [32:0] ofs, input logic [1:0] kind);
    logic [32:0] lim, ceil;
    logic top, ok, forbid;
    lim  = m_g ? {1'b0, m_raw, 12'hFFF} : {13'd0, m_raw};
    ceil = m_d ? 33'h0FFFFFFFF : 33'h00000FFFF;
    top  = (m_ar & 8'h1C) == 8'h14;
    ok   = (ofs <= lim) ^ top;
    if (top && ofs > ceil) ok = 1'b0;
    if (m_ar[3]) forbid = m_ar[1] ? (kind == 2'd0) : (kind != 2'd3);
    else         forbid = m_ar[1] ? 1'b0 : (kind == 2'd0);
    if (!m_ar[7])              return 3'd1;
    if (m_ar[4] && forbid)     return 3'd3;
    if (!ok)                   return 3'd6;
    return 3'd0;
  endfunction

  task automatic do_access(input logic [32:0] ofs, input logic [1:0] kind,
                           input logic pf, input logic stk, input logic [1:0] mode,
                           input string ltag);
    logic [2:0] c;
    logic f;
    c = exp_cause(ofs, kind);
    f = (c != 3'd0);
    acc_valid = 1'b1;
    acc_offset = ofs; acc_kind = kind; acc_prefetch = pf;
    acc_is_stack = stk; acc_mode = mode;
    @(negedge clk);
    check("R11 valid", res_valid, 1);
    check((c == 3'd3) ? "R5 cause" : (c == 3'd6 || c == 3'd0) ? ltag : "R6 cause",
          res_cause, c);
    check("R6 fault", res_fault, f);
    check("R7 class", res_stack_fault, (c == 3'd6) && stk);
    check("R8 raise", res_raise, f && !pf);
    check("R9 pseudo", res_pseudo, f && (mode == 2'd0 || (mode == 2'd2 && c == 3'd6)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] offs [8];
    rst = 1'b1; load_en = 1'b0; acc_valid = 1'b0;
    load_limit = '0; load_base_lo = '0; load_base_mid = '0; load_base_hi = '0;
    load_present = 0; load_cd = 0; load_type = 0; load_gran = 0; load_db = 0;
    acc_offset = '0; acc_kind = 0; acc_prefetch = 0; acc_is_stack = 0; acc_mode = 0;
    m_ar = 0; m_raw = 0; m_g = 0; m_d = 0;
    repeat (3) @(negedge clk);
    check("R10 valid", res_valid, 0);
    check("R10 fault", res_fault, 0);
    check("R10 cause", res_cause, 0);
    check("R10 raise", res_raise | res_pseudo | res_stack_fault, 0);
    check("R10 base", seg_base, 0);
    rst = 1'b0;

    // R2 base assembly
    load_desc(8'h92, 20'h00123, 0, 1, 32'hA5C3_1E77);
    check("R2 base", seg_base, 32'hA5C31E77);
    load_desc(8'h92, 20'h00123, 0, 1, 32'h0102_F00D);
    check("R2 base", seg_base, 32'h0102F00D);

    // R1 page granularity full range
    load_desc(8'h92, 20'hFFFFF, 1, 1, 32'h0);
    do_access(33'h0FFFFFFFF, 2'd1, 0, 0, 2'd1, "R1 limit");
    check("R1 top passes", res_fault, 0);
    do_access(33'h100000000, 2'd1, 0, 0, 2'd1, "R1 limit");
    check("R1 beyond fails", res_cause, 6);

    // R4 expand-down with 16-bit ceiling
    load_desc(8'h96, 20'h00FFF, 0, 0, 32'h0);
    do_access(33'h0000FFFF, 2'd0, 0, 1, 2'd1, "R4 ceiling");
    check("R4 at ceiling passes", res_fault, 0);
    do_access(33'h00010000, 2'd0, 0, 1, 2'd1, "R4 ceiling");
    check("R4 over ceiling stack fault", res_stack_fault, 1);
    do_access(33'h00000FFF, 2'd0, 0, 0, 2'd1, "R3 inversion");
    check("R3 at limit fails", res_cause, 6);

    // R11 load in same cycle as access uses the previous descriptor
    load_desc(8'h92, 20'h00123, 0, 1, 32'h0);
    acc_valid = 1'b1; acc_offset = 33'h10; acc_kind = 2'd1;
    acc_prefetch = 0; acc_is_stack = 0; acc_mode = 2'd1;
    load_en = 1'b1; load_present = 1'b0;
    @(negedge clk);
    load_en = 1'b0; m_ar = 8'h12;
    check("R11 old descriptor used", res_cause, 0);
    @(negedge clk);
    check("R11 new descriptor used", res_cause, 1);

    // full sweep: presence, class, type, granularity, size
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 8; t++)
          for (int g = 0; g < 2; g++)
            for (int d = 0; d < 2; d++) begin
              logic [7:0] ar;
              logic [32:0] lim;
              ar = {p[0], 2'b00, s[0], t[2:0], 1'b0};
              load_desc(ar, 20'h00123, g[0], d[0], {t[7:0], 8'h5A, 8'(s), 8'(g)});
              lim = g ? 33'h000123FFF : 33'h000000123;
              offs[0] = 33'h0;        offs[1] = lim - 1;
              offs[2] = lim;          offs[3] = lim + 1;
              offs[4] = 33'h0FFFF;    offs[5] = 33'h10000;
              offs[6] = 33'h0FFFFFFFF; offs[7] = 33'h100000000;
              for (int o = 0; o < 8; o++)
                for (int k = 0; k < 4; k++)
                  for (int pf = 0; pf < 2; pf++)
                    for (int st = 0; st < 2; st++)
                      for (int md = 0; md < 3; md++)
                        do_access(offs[o], k[1:0], pf[0], st[0], md[1:0],
                                  ((ar & 8'h1C) == 8'h14) ? (d ? "R4 limit" : "R3 limit")
                                                          : "R1 limit");
            end

    acc_valid = 1'b0;
    @(negedge clk);
    check("R11 idle", res_valid, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule